// File: doc/BRIEF.md
# Prefetching Instruction Byte Queue

This block sits between a word-wide memory port and the execution datapath of a byte-coded stack machine. It reads aligned 32-bit words ahead of need and appends their bytes to a short shift queue. The datapath sees the head of that queue through two views: the oldest byte alone, and the oldest two bytes as a pair. Each view is offered both sign-extended and zero-extended to 32 bits. Instructions are not word-aligned, so a two-byte operand may straddle two memory words. The queue hides that seam from the datapath.

The datapath pulses a one-byte or a two-byte consume strobe when it uses a view. The queue then shifts by that many bytes. Whenever the queue has room for another whole word and no read is in flight, it issues the next word read on its own. A program-counter load flushes the queue and drops the result of any read still in flight. Fetching then resumes from the new address, and any leading bytes of the first word that lie below that address are thrown away.

Top module: `ifu_byte_queue`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, both valid flags are low. The first read request carries the word address of `RESET_PC`.
- R2: Reads are aligned to 4 bytes, and at most one is outstanding. The byte at address offset k of a word arrives on `mem_rdata[8k+7:8k]`. Bytes join the queue in ascending address order.
- R3: The one-byte view shows the oldest queued byte. The two-byte view places the oldest byte in bits 15:8 and the next-oldest byte in bits 7:0.
- R4: The `_sext` outputs copy bit 7 (one-byte view) or bit 15 (two-byte view) into every upper bit. The `_zext` outputs fill the upper bits with zeros.
- R5: An accepted `take_one` removes one byte and an accepted `take_two` removes two. If both are high and the pair view is valid, only the two-byte consume happens.
- R6: A read is requested only when occupancy is at most `QBYTES`-4 and no read is outstanding. Left undrained, an 8-byte queue started at an aligned address issues exactly two reads and then waits.
- R7: A two-byte operand whose bytes lie in different memory words is presented intact, in address order.
- R8: Once the queue holds bytes, `take_one` can be accepted on every cycle with no stall.
- R9: `one_valid` is high when occupancy is 1 or more. `pair_valid` is high when occupancy is 2 or more. A strobe raised while its flag is low does nothing.
- R10: `pc_load` empties the queue at once and discards the data of any read still in flight. Fetching restarts from the word that holds `pc_value`, and the bytes of that word below `pc_value` are dropped.
- R11: When a word arrives in the same cycle as a consume, the queue shifts first and then appends, and no byte is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_load | input | 1 | Redirect strobe: flush and restart fetch |
| pc_value | input | ADDR_W | Byte address to restart from |
| take_one | input | 1 | Datapath used the one-byte view |
| take_two | input | 1 | Datapath used the two-byte view |
| mem_req | output | 1 | Word read request, one cycle |
| mem_addr | output | ADDR_W | Aligned word address of the request |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data, lowest address in bits 7:0 |
| one_sext | output | 32 | Oldest byte, sign-extended |
| one_zext | output | 32 | Oldest byte, zero-extended |
| pair_sext | output | 32 | Oldest two bytes, sign-extended |
| pair_zext | output | 32 | Oldest two bytes, zero-extended |
| one_valid | output | 1 | At least one byte queued |
| pair_valid | output | 1 | At least two bytes queued |

## Verification
The bench builds the block with `QBYTES` = 8, `ADDR_W` = 32 and `RESET_PC` = 0x40. It drives the memory model with read latencies of 1, 2 and 6 cycles. With an 8-byte queue, the fetch threshold of 4 free bytes can be counted directly: an undrained queue settles after exactly two reads. The short latency makes word arrivals coincide with consumes, while the long one leaves a read in flight when a redirect to the unaligned address 0x103 lands. That redirect yields a first word carrying one useful byte.

// File: rtl/ifu_pkg.sv
package ifu_pkg;
  localparam int WORD_BYTES = 4;
  localparam int WORD_W     = 8 * WORD_BYTES;
  localparam int LANE_W     = $clog2(WORD_BYTES);
  typedef logic [7:0] qbyte_t;
endpackage

// File: rtl/ifu_fetch_ctl.sv
module ifu_fetch_ctl
  import ifu_pkg::*;
#(
  parameter int              ADDR_W   = 32,
  parameter int              QBYTES   = 8,
  parameter int              CNT_W    = 4,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pc_load,
  input  logic [ADDR_W-1:0] pc_value,
  input  logic [CNT_W-1:0]  occ,
  input  logic              mem_ack,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              accept,
  output logic [LANE_W-1:0] skip
);
  localparam logic [CNT_W-1:0]  FETCH_LIMIT = CNT_W'(QBYTES - WORD_BYTES);
  localparam logic [ADDR_W-1:0] WORD_STEP   = ADDR_W'(WORD_BYTES);

  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [LANE_W-1:0] skip_q, skip_n;
  logic              pend_q, pend_n;
  logic              stale_q, stale_n;

  assign mem_req  = !pend_q && !pc_load && (occ <= FETCH_LIMIT);
  assign mem_addr = addr_q;
  assign accept   = mem_ack && pend_q && !stale_q && !pc_load;
  assign skip     = skip_q;

  always_comb begin
    addr_n  = addr_q;
    skip_n  = skip_q;
    pend_n  = pend_q;
    stale_n = stale_q;
    if (pc_load) begin
      addr_n  = {pc_value[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
      skip_n  = pc_value[LANE_W-1:0];
      pend_n  = pend_q && !mem_ack;
      stale_n = pend_q && !mem_ack;
    end else begin
      if (mem_ack) begin
        pend_n  = 1'b0;
        stale_n = 1'b0;
      end
      if (accept) skip_n = '0;
      if (mem_req) begin
        pend_n = 1'b1;
        addr_n = addr_q + WORD_STEP;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= {RESET_PC[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
      skip_q  <= RESET_PC[LANE_W-1:0];
      pend_q  <= 1'b0;
      stale_q <= 1'b0;
    end else begin
      addr_q  <= addr_n;
      skip_q  <= skip_n;
      pend_q  <= pend_n;
      stale_q <= stale_n;
    end
  end
endmodule

// File: rtl/ifu_byte_q.sv
module ifu_byte_q
  import ifu_pkg::*;
#(
  parameter int QBYTES = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [1:0]        take_cnt,
  input  logic              app_en,
  input  logic [WORD_W-1:0] app_word,
  input  logic [LANE_W-1:0] app_skip,
  output qbyte_t            head0,
  output qbyte_t            head1,
  output logic [CNT_W-1:0]  occ
);
  qbyte_t           q_r [QBYTES];
  qbyte_t           q_n [QBYTES];
  logic [CNT_W-1:0] occ_q, occ_n, occ_sh;
  logic             q_en;

  assign q_en  = app_en || (take_cnt != 2'd0);
  assign head0 = q_r[0];
  assign head1 = q_r[1];
  assign occ   = occ_q;

  always_comb begin
    occ_sh = occ_q - CNT_W'(take_cnt);
    for (int i = 0; i < QBYTES; i++) begin
      q_n[i] = q_r[i];
      case (take_cnt)
        2'd1: q_n[i] = (i + 1 < QBYTES) ? q_r[(i + 1) % QBYTES] : '0;
        2'd2: q_n[i] = (i + 2 < QBYTES) ? q_r[(i + 2) % QBYTES] : '0;
        default: ;
      endcase
    end
    if (app_en) begin
      for (int i = 0; i < QBYTES; i++) begin
        for (int j = 0; j < WORD_BYTES; j++) begin
          if ((j >= int'(app_skip)) &&
              (i == int'(occ_sh) + j - int'(app_skip)))
            q_n[i] = app_word[8*j +: 8];
        end
      end
    end
    if (flush)       occ_n = '0;
    else if (app_en) occ_n = occ_sh + CNT_W'(WORD_BYTES) - CNT_W'(app_skip);
    else             occ_n = occ_sh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ_q <= '0;
    else        occ_q <= occ_n;
  end

  always_ff @(posedge clk) begin
    if (q_en) begin
      for (int i = 0; i < QBYTES; i++) q_r[i] <= q_n[i];
    end
  end
endmodule

// File: rtl/ifu_view_ext.sv
module ifu_view_ext
  import ifu_pkg::*;
#(
  parameter int OUT_W = 32
) (
  input  qbyte_t           head0,
  input  qbyte_t           head1,
  output logic [OUT_W-1:0] one_sext,
  output logic [OUT_W-1:0] one_zext,
  output logic [OUT_W-1:0] pair_sext,
  output logic [OUT_W-1:0] pair_zext
);
  logic [15:0] pair;
  assign pair      = {head0, head1};
  assign one_sext  = {{(OUT_W-8){head0[7]}}, head0};
  assign one_zext  = {{(OUT_W-8){1'b0}}, head0};
  assign pair_sext = {{(OUT_W-16){pair[15]}}, pair};
  assign pair_zext = {{(OUT_W-16){1'b0}}, pair};
endmodule

// File: rtl/ifu_byte_queue.sv
module ifu_byte_queue
  import ifu_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter int                QBYTES   = 8,
  parameter logic [ADDR_W-1:0] RESET_PC = 32'h0000_0040
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pc_load,
  input  logic [ADDR_W-1:0] pc_value,
  input  logic              take_one,
  input  logic              take_two,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic [31:0]       one_sext,
  output logic [31:0]       one_zext,
  output logic [31:0]       pair_sext,
  output logic [31:0]       pair_zext,
  output logic              one_valid,
  output logic              pair_valid
);
  localparam int CNT_W = $clog2(QBYTES + 1);

  logic [CNT_W-1:0]  occ;
  logic [1:0]        take_cnt;
  logic              accept;
  logic [LANE_W-1:0] skip;
  qbyte_t            head0, head1;

  assign one_valid  = (occ >= CNT_W'(1));
  assign pair_valid = (occ >= CNT_W'(2));

  always_comb begin
    take_cnt = 2'd0;
    if (!pc_load) begin
      if (take_two && pair_valid)     take_cnt = 2'd2;
      else if (take_one && one_valid) take_cnt = 2'd1;
    end
  end

  ifu_fetch_ctl #(
    .ADDR_W(ADDR_W), .QBYTES(QBYTES), .CNT_W(CNT_W), .RESET_PC(RESET_PC)
  ) u_fetch (
    .clk(clk), .rst_n(rst_n), .pc_load(pc_load), .pc_value(pc_value),
    .occ(occ), .mem_ack(mem_ack), .mem_req(mem_req), .mem_addr(mem_addr),
    .accept(accept), .skip(skip)
  );

  ifu_byte_q #(.QBYTES(QBYTES), .CNT_W(CNT_W)) u_q (
    .clk(clk), .rst_n(rst_n), .flush(pc_load), .take_cnt(take_cnt),
    .app_en(accept), .app_word(mem_rdata), .app_skip(skip),
    .head0(head0), .head1(head1), .occ(occ)
  );

  ifu_view_ext #(.OUT_W(32)) u_ext (
    .head0(head0), .head1(head1),
    .one_sext(one_sext), .one_zext(one_zext),
    .pair_sext(pair_sext), .pair_zext(pair_zext)
  );
endmodule

// File: rtl/ifu_byte_queue_chk.sv
module ifu_byte_queue_chk #(
  parameter int ADDR_W = 32,
  parameter int QBYTES = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pc_load,
  input logic              take_one,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack,
  input logic              one_valid,
  input logic              pair_valid,
  input logic [31:0]       one_sext,
  input logic [31:0]       one_zext,
  input logic [31:0]       pair_zext,
  input logic [CNT_W-1:0]  occ
);
  a_r2_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  a_r2_aligned_addr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));
  a_r6_no_overfill: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CNT_W'(QBYTES));
  a_r3_pair_order: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> (pair_zext[15:8] == one_zext[7:0]));
  a_r4_extend: assert property (@(posedge clk) disable iff (!rst_n)
    one_valid |-> ((one_zext[31:8] == 24'd0) && (one_sext[7:0] == one_zext[7:0])
                   && (one_sext[31] == one_zext[7])));
  a_r9_flag_levels: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid |-> one_valid);
  a_r9_ignored_take: assert property (@(posedge clk) disable iff (!rst_n)
    (!one_valid && take_one && !mem_ack) |=> !one_valid);
  a_r10_flush: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> !one_valid);
endmodule

bind ifu_byte_queue ifu_byte_queue_chk #(
  .ADDR_W(ADDR_W), .QBYTES(QBYTES), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pc_load(pc_load), .take_one(take_one),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
  .one_valid(one_valid), .pair_valid(pair_valid), .one_sext(one_sext),
  .one_zext(one_zext), .pair_zext(pair_zext), .occ(occ)
);

// File: tb/ifu_byte_queue_tb.sv
`timescale 1ns/1ps
module ifu_byte_queue_tb;
  typedef struct {
    bit          two;
    logic [31:0] sx;
    logic [31:0] zx;
    string       req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        pc_load, take_one, take_two, mem_ack;
  logic [31:0] pc_value, mem_rdata, mem_addr;
  logic        mem_req;
  logic [31:0] one_sext, one_zext, pair_sext, pair_zext;
  logic        one_valid, pair_valid;

  int errors = 0;
  int checks = 0;
  int mem_lat = 2;
  int req_cnt = 0;
  int stalls = 0;
  bit busy = 0;
  logic [31:0] exp_addr;
  logic [31:0] first_req_addr;
  exp_t sb[$];

  always #2 clk = ~clk;

  ifu_byte_queue #(.ADDR_W(32), .QBYTES(8), .RESET_PC(32'h40)) u_dut (
    .clk(clk), .rst_n(rst_n), .pc_load(pc_load), .pc_value(pc_value),
    .take_one(take_one), .take_two(take_two), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .one_sext(one_sext), .one_zext(one_zext), .pair_sext(pair_sext),
    .pair_zext(pair_zext), .one_valid(one_valid), .pair_valid(pair_valid)
  );

  function automatic logic [7:0] mb(input logic [31:0] a);
    logic [31:0] t;
    t = a * 32'd13 + (a >> 8) + 32'd33;
    return t[7:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: one read at a time, latency mem_lat cycles
  initial begin
    mem_ack = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (rst_n && mem_req) begin
        logic [31:0] a;
        a = mem_addr;
        req_cnt++;
        if (req_cnt == 1) first_req_addr = a;
        busy = 1;
        repeat (mem_lat) @(posedge clk);
        #1;
        mem_ack = 1'b1;
        for (int k = 0; k < 4; k++) mem_rdata[8*k +: 8] = mb(a + 32'(k));
        @(posedge clk);
        #1;
        mem_ack = 1'b0;
        busy = 0;
      end
    end
  end

  // monitor: pops expected items as consumes are accepted
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && !pc_load && ((take_two && pair_valid) || (take_one && one_valid))) begin
        if (sb.size() == 0) begin
          checks++; errors++;
          $display("FAIL R5 actual=unexpected consume expected=none");
        end else begin
          exp_t e;
          e = sb.pop_front();
          if (e.two) begin
            check(e.req, pair_sext, e.sx);
            check(e.req, pair_zext, e.zx);
          end else begin
            check(e.req, one_sext, e.sx);
            check(e.req, one_zext, e.zx);
          end
        end
      end
    end
  end

  // driver: entered at posedge+1, leaves at posedge+1
  task automatic take(input int n, input bit both, input string req);
    exp_t e;
    while (!(n == 2 ? pair_valid : one_valid)) begin
      stalls++;
      @(posedge clk); #1;
    end
    e.two = (n == 2);
    e.req = req;
    if (n == 2) begin
      e.zx = {16'd0, mb(exp_addr), mb(exp_addr + 1)};
      e.sx = {{16{e.zx[15]}}, e.zx[15:0]};
    end else begin
      e.zx = {24'd0, mb(exp_addr)};
      e.sx = {{24{e.zx[7]}}, e.zx[7:0]};
    end
    sb.push_back(e);
    exp_addr = exp_addr + 32'(n);
    take_two = (n == 2);
    take_one = (n == 1) || both;
    @(posedge clk); #1;
    take_one = 1'b0;
    take_two = 1'b0;
  endtask

  task automatic redirect(input logic [31:0] v);
    pc_load = 1'b1;
    pc_value = v;
    sb.delete();
    exp_addr = v;
    req_cnt = 0;
    @(posedge clk); #1;
    pc_load = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    pc_load = 1'b0; pc_value = '0;
    take_one = 1'b0; take_two = 1'b0;
    exp_addr = 32'h40;
    repeat (3) @(posedge clk);
    #1;
    check("R1 one_valid in reset", {31'd0, one_valid}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 one_valid after reset", {31'd0, one_valid}, 32'd0);
    check("R1 pair_valid after reset", {31'd0, pair_valid}, 32'd0);
    check("R1 first request", {31'd0, mem_req}, 32'd1);
    check("R1 first address", mem_addr, 32'h40);
    @(posedge clk); #1;

    // R6: undrained queue stops after two words
    repeat (20) @(posedge clk);
    #1;
    check("R6 read count when full", 32'(req_cnt), 32'd2);
    check("R9 pair_valid when full", {31'd0, pair_valid}, 32'd1);

    // R8: four back-to-back single takes, no stall; R3 R4 via monitor
    stalls = 0;
    for (int i = 0; i < 4; i++) take(1, 0, "R3 R4 one-byte view");
    check("R8 stall cycles in burst", 32'(stalls), 32'd0);

    // R7: pair straddling a word boundary (0x47, 0x48)
    for (int i = 0; i < 3; i++) take(1, 0, "R3 one-byte view");
    take(2, 0, "R7 pair across words");
    // R5: both strobes -> two-byte consume only
    take(2, 1, "R5 both strobes");
    take(1, 0, "R5 next byte after both");

    // R11: short latency, mixed stream with arrivals during consumes
    mem_lat = 1;
    for (int i = 0; i < 40; i++) take((i % 3 == 1) ? 2 : 1, 0, "R11 stream");
    repeat (4) @(posedge clk);
    #1;

    // R10: redirect while a read is in flight, to an unaligned address
    mem_lat = 6;
    while (!busy) take(1, 0, "R2 drain to trigger read");
    redirect(32'h103);
    @(negedge clk);
    check("R10 flush on redirect", {31'd0, one_valid}, 32'd0);
    @(posedge clk); #1;
    // R9: strobe while empty is ignored
    take_one = 1'b1;
    take_two = 1'b1;
    @(negedge clk);
    check("R9 still empty after ignored take", {31'd0, one_valid}, 32'd0);
    @(posedge clk); #1;
    take_one = 1'b0;
    take_two = 1'b0;
    repeat (40) @(posedge clk);
    #1;
    check("R10 first address after redirect", first_req_addr, 32'h100);
    check("R6 reads after unaligned redirect", 32'(req_cnt), 32'd2);
    check("R10 pair_valid with 5 bytes", {31'd0, pair_valid}, 32'd1);
    for (int i = 0; i < 6; i++) take(1, 0, "R10 bytes from new pc");
    take(2, 0, "R2 R7 pair after redirect");
    repeat (4) @(posedge clk);
    #1;
    check("R5 scoreboard drained", 32'(sb.size()), 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule